// File: doc/BRIEF.md
# Register-select parallel bus interface

This block sits between a microcontroller's parallel bus and the internal core of a display controller. The host drives an enable strobe, a register-select line and a read/write line, plus an 8-bit data bus. A bus cycle completes on the falling edge of the enable strobe. Before any decision is made, that edge is brought into the system clock domain through a synchronizer.

With the select line low, a write carries an instruction byte to the core. A read with the select line low returns a status byte: the core's busy flag and its 7-bit address counter. The instruction register behind the bus can be written but never read back. With the select line high, a write carries a data byte to the core. A read with the select line high returns the data register, which the core loads from its RAM ahead of the read. When a data read completes, the block sends one advance pulse so that the core can step its address counter and prefetch the next byte.

A mode input selects 4-bit operation. In that mode only data lines 7..4 carry information, and every byte takes two strobes, upper nibble first. The host must hold the select line, the read/write line and the data lines stable from the rising edge of the strobe until four clock cycles after its falling edge.

Top module: `rsb_host_if`

## Requirements
- R1: When not busy, a completed write with `bus_rs`=0 produces a single-cycle `ins_stb`, with the written byte on `wr_byte`.
- R2: A completed write with `bus_rs`=1 produces a single-cycle `dat_stb`, with the written byte on `wr_byte`, whatever the value of `core_busy`.
- R3: A completion pulse (`ins_stb`, `dat_stb` or `rd_adv`) goes high after the third rising clock edge, counting the first edge that samples `bus_en` low. It lasts exactly one cycle, and at most one of the three pulses is high in any cycle.
- R4: A read with `bus_rs`=0 drives `bus_dout` = {`core_busy` on bit 7, `core_ac` on bits 6..0}.
- R5: The instruction byte is never readable: after an instruction write, a `bus_rs`=0 read still returns the status byte of R4.
- R6: A read with `bus_rs`=1 drives the data register, which `core_load` loads from `core_ldata` on a clock edge. Only a completed data read produces one `rd_adv` pulse; status reads and writes produce none.
- R7: A completed instruction write while `core_busy`=1 is ignored: no `ins_stb` is produced and `wr_byte` is unchanged.
- R8: With `four_bit`=1, only `bus_din[7:4]` is used. The first strobe carries the upper nibble and the second strobe completes the byte. Reads present the upper nibble and then the lower nibble on `bus_dout[7:4]`, with `bus_dout[3:0]`=0.
- R9: Any change of `four_bit` returns the nibble phase to the upper-nibble position.
- R10: `bus_oe` is high only while `bus_en`=1 and `bus_rw`=1. `bus_dout` is 0 whenever `bus_oe` is low.
- R11: Out of reset no pulse is active, the nibble phase is at the upper nibble, and the data register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Host enable strobe (asynchronous); the falling edge completes a cycle |
| bus_rs | input | 1 | Register select: 0 selects instruction/status, 1 selects data |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_din | input | 8 | Host data in |
| bus_dout | output | 8 | Data driven to the host |
| bus_oe | output | 1 | Output enable for the data lines |
| four_bit | input | 1 | 1 selects 4-bit nibble transfers |
| core_busy | input | 1 | Core busy flag |
| core_ac | input | 7 | Core address counter |
| core_load | input | 1 | Loads the data register from `core_ldata` |
| core_ldata | input | 8 | Prefetched RAM byte |
| ins_stb | output | 1 | Instruction accepted pulse |
| dat_stb | output | 1 | Data write pulse |
| rd_adv | output | 1 | Data read completed pulse |
| wr_byte | output | 8 | Last accepted write byte |

## Verification
A nibble phase that is out of step shows on the very next 4-bit read as the wrong half of the byte on `bus_dout[7:4]`. It also shows as a write pulse one strobe early or late, carrying a mis-assembled byte. A fault in the synchronizer or in the edge detector moves a completion pulse off the third clock edge after the strobe falls, and the per-clock comparison catches this in that same cycle. A lost busy gate or a wrong select decode shows at the ports within one cycle of the completion edge, as an unexpected or missing pulse.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int AC_W   = BYTE_W - 1;

  function automatic logic [BYTE_W-1:0] status_byte(input logic busy,
                                                    input logic [AC_W-1:0] ac);
    return {busy, ac};
  endfunction

  // Picks what the host sees on the data lines for the current nibble phase.
  function automatic logic [BYTE_W-1:0] nibble_view(input logic [BYTE_W-1:0] v,
                                                    input logic four,
                                                    input logic lower);
    if (!four) return v;
    if (lower) return {v[NIB_W-1:0], {NIB_W{1'b0}}};
    return {v[BYTE_W-1:NIB_W], {NIB_W{1'b0}}};
  endfunction
endpackage

// File: rtl/rsb_fall_sync.sv
module rsb_fall_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic fall
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign fall = sh[STAGES] & ~sh[STAGES-1];
endmodule

// File: rtl/rsb_nibble_track.sv
module rsb_nibble_track
  import rsb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             four_bit,
  input  logic             step,
  input  logic [NIB_W-1:0] nib_in,
  output logic             phase,
  output logic [NIB_W-1:0] hi_hold,
  output logic             byte_done
);
  logic mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      phase   <= 1'b0;
      hi_hold <= '0;
    end else begin
      mode_q <= four_bit;
      if (four_bit != mode_q)      phase <= 1'b0;
      else if (step && four_bit)   phase <= ~phase;
      if (step && four_bit && !phase) hi_hold <= nib_in;
    end
  end

  assign byte_done = step & (~four_bit | phase);
endmodule

// File: rtl/rsb_host_if.sv
module rsb_host_if
  import rsb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_rs,
  input  logic              bus_rw,
  input  logic [BYTE_W-1:0] bus_din,
  output logic [BYTE_W-1:0] bus_dout,
  output logic              bus_oe,
  input  logic              four_bit,
  input  logic              core_busy,
  input  logic [AC_W-1:0]   core_ac,
  input  logic              core_load,
  input  logic [BYTE_W-1:0] core_ldata,
  output logic              ins_stb,
  output logic              dat_stb,
  output logic              rd_adv,
  output logic [BYTE_W-1:0] wr_byte
);
  logic              fall_evt;
  logic              nib_phase;
  logic [NIB_W-1:0]  hi_hold;
  logic              byte_done;
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] asm_byte;
  logic [BYTE_W-1:0] rd_src;

  rsb_fall_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(bus_en), .fall(fall_evt)
  );

  rsb_nibble_track u_nib (
    .clk(clk), .rst_n(rst_n), .four_bit(four_bit), .step(fall_evt),
    .nib_in(bus_din[BYTE_W-1:NIB_W]), .phase(nib_phase),
    .hi_hold(hi_hold), .byte_done(byte_done)
  );

  assign asm_byte = four_bit ? {hi_hold, bus_din[BYTE_W-1:NIB_W]} : bus_din;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_stb <= 1'b0;
      dat_stb <= 1'b0;
      rd_adv  <= 1'b0;
      wr_byte <= '0;
      data_q  <= '0;
    end else begin
      ins_stb <= 1'b0;
      dat_stb <= 1'b0;
      rd_adv  <= 1'b0;
      if (core_load) data_q <= core_ldata;
      if (byte_done) begin
        if (!bus_rw) begin
          if (bus_rs) begin
            dat_stb <= 1'b1;
            wr_byte <= asm_byte;
          end else if (!core_busy) begin
            ins_stb <= 1'b1;
            wr_byte <= asm_byte;
          end
        end else if (bus_rs) begin
          rd_adv <= 1'b1;
        end
      end
    end
  end

  assign bus_oe   = bus_en & bus_rw;
  assign rd_src   = bus_rs ? data_q : status_byte(core_busy, core_ac);
  assign bus_dout = bus_oe ? nibble_view(rd_src, four_bit, nib_phase) : '0;
endmodule

// File: rtl/rsb_host_if_checker.sv
module rsb_host_if_checker (
  input logic clk,
  input logic rst_n,
  input logic bus_en,
  input logic bus_rw,
  input logic bus_oe,
  input logic four_bit,
  input logic core_busy,
  input logic ins_stb,
  input logic dat_stb,
  input logic rd_adv,
  input logic fall_evt,
  input logic nib_phase
);
  a_r1_ins_single: assert property (@(posedge clk) disable iff (!rst_n)
    ins_stb |=> !ins_stb);
  a_r3_pulse_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_stb || dat_stb || rd_adv) |-> $past(fall_evt));
  a_r3_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ins_stb, dat_stb, rd_adv}));
  a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ins_stb |-> !$past(core_busy));
  a_r9_phase_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (four_bit != $past(four_bit)) |=> !nib_phase);
  a_r10_oe_gate: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (bus_en && bus_rw));
endmodule

bind rsb_host_if rsb_host_if_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rw(bus_rw), .bus_oe(bus_oe),
  .four_bit(four_bit), .core_busy(core_busy), .ins_stb(ins_stb),
  .dat_stb(dat_stb), .rd_adv(rd_adv), .fall_evt(fall_evt), .nib_phase(nib_phase)
);

// File: tb/tb_rsb_host_if.sv
module tb_rsb_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_rs = 1'b0, bus_rw = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout;
  logic bus_oe;
  logic four_bit = 1'b0, core_busy = 1'b0, core_load = 1'b0;
  logic [6:0] core_ac = '0;
  logic [7:0] core_ldata = '0;
  logic ins_stb, dat_stb, rd_adv;
  logic [7:0] wr_byte;

  int checks = 0, fails = 0;
  int cyc = 0, fall_cyc = 0, pulse_cyc = 0;
  int n_ins = 0, n_dat = 0, n_adv = 0;
  logic [7:0] last_ins = '0, last_dat = '0;

  // behavioural reference state
  bit h1, h2, h3;
  bit m_phase, m_mode;
  logic [3:0] m_hi;
  logic [7:0] m_data, m_byte;
  bit e_ins, e_dat, e_adv;

  always #5 clk = ~clk;

  rsb_host_if dut (.*);

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      {h1, h2, h3, m_phase, m_mode, e_ins, e_dat, e_adv} = '0;
      m_hi = '0; m_data = '0; m_byte = '0;
    end else begin
      bit fell, done;
      logic [7:0] b;
      fell = h3 && !h2;
      e_ins = 0; e_dat = 0; e_adv = 0;
      if (core_load) m_data = core_ldata;
      done = fell && (!four_bit || m_phase);
      b = four_bit ? {m_hi, bus_din[7:4]} : bus_din;
      if (done && !bus_rw) begin
        if (bus_rs) begin e_dat = 1; m_byte = b; end
        else if (!core_busy) begin e_ins = 1; m_byte = b; end
      end
      if (done && bus_rw && bus_rs) e_adv = 1;
      if (fell && four_bit && !m_phase) m_hi = bus_din[7:4];
      if (four_bit != m_mode) m_phase = 0;
      else if (fell && four_bit) m_phase = !m_phase;
      m_mode = four_bit;
      h3 = h2; h2 = h1; h1 = bus_en;
    end
  end

  // per-clock comparison against the model, plus pulse bookkeeping
  always @(negedge clk) begin
    logic [7:0] src, view;
    check(ins_stb == e_ins, "R1/R7 ins_stb", ins_stb, e_ins);
    check(dat_stb == e_dat, "R2 dat_stb", dat_stb, e_dat);
    check(rd_adv == e_adv, "R6 rd_adv", rd_adv, e_adv);
    check(bus_oe == (bus_en && bus_rw), "R10 bus_oe", bus_oe, bus_en && bus_rw);
    if (ins_stb || dat_stb) check(wr_byte == m_byte, "R1/R2 wr_byte", wr_byte, m_byte);
    src = bus_rs ? m_data : {core_busy, core_ac};
    view = !four_bit ? src : (m_phase ? {src[3:0], 4'h0} : {src[7:4], 4'h0});
    if (!bus_oe) view = 8'h00;
    check(bus_dout == view, "R4/R6/R8 bus_dout", bus_dout, view);
    if (ins_stb) begin n_ins++; last_ins = wr_byte; end
    if (dat_stb) begin n_dat++; last_dat = wr_byte; end
    if (rd_adv) n_adv++;
    if (ins_stb || dat_stb || rd_adv) pulse_cyc = cyc;
  end

  task automatic xfer(input bit rs, input bit rw, input logic [7:0] d,
                      output logic [7:0] rd);
    @(negedge clk);
    bus_rs = rs; bus_rw = rw; bus_din = d; bus_en = 1'b1;
    repeat (3) @(negedge clk);
    if (!rw) check(bus_oe == 1'b0, "R10 oe low on write", bus_oe, 0);
    rd = bus_dout;
    @(negedge clk);
    bus_en = 1'b0; fall_cyc = cyc;
    repeat (5) @(negedge clk);
  endtask

  task automatic load_dr(input logic [7:0] v);
    @(negedge clk);
    core_ldata = v; core_load = 1'b1;
    @(negedge clk);
    core_load = 1'b0;
  endtask

  task automatic set_mode(input bit f);
    @(negedge clk);
    four_bit = f;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] r, r2;
    int n0;
    repeat (4) @(negedge clk);
    // R11 reset state
    check(!ins_stb && !dat_stb && !rd_adv, "R11 pulses in reset", {ins_stb, dat_stb, rd_adv}, 0);
    check(bus_oe == 0 && bus_dout == 0, "R11 oe in reset", bus_oe, 0);
    rst_n = 1'b1;
    core_ac = 7'h15;

    // R1 instruction write, R3 timing
    n0 = n_ins;
    xfer(0, 0, 8'h38, r);
    check(n_ins == n0 + 1 && last_ins == 8'h38, "R1 instr write", last_ins, 8'h38);
    check(pulse_cyc - fall_cyc == 3, "R3 pulse timing", pulse_cyc - fall_cyc, 3);

    // R2 data write
    n0 = n_dat;
    xfer(1, 0, 8'h5A, r);
    check(n_dat == n0 + 1 && last_dat == 8'h5A, "R2 data write", last_dat, 8'h5A);

    // R4 status read
    n0 = n_adv;
    xfer(0, 1, 8'h00, r);
    check(r == 8'h15, "R4 status idle", r, 8'h15);
    check(n_adv == n0, "R6 no adv on status read", n_adv, n0);
    core_busy = 1'b1; core_ac = 7'h7F;
    xfer(0, 1, 8'h00, r);
    check(r == 8'hFF, "R4 status busy", r, 8'hFF);

    // R7 busy ignores instruction, accepts data
    n0 = n_ins;
    xfer(0, 0, 8'h01, r);
    check(n_ins == n0, "R7 ignored while busy", n_ins, n0);
    check(wr_byte == 8'h5A, "R7 wr_byte unchanged", wr_byte, 8'h5A);
    n0 = n_dat;
    xfer(1, 0, 8'h77, r);
    check(n_dat == n0 + 1 && last_dat == 8'h77, "R7 data while busy", last_dat, 8'h77);
    core_busy = 1'b0; core_ac = 7'h2C;

    // R5 instruction not readable
    xfer(0, 0, 8'hA5, r);
    xfer(0, 1, 8'h00, r);
    check(r == 8'h2C, "R5 status after instr", r, 8'h2C);

    // R6 data read from loaded register
    load_dr(8'hC3);
    n0 = n_adv;
    xfer(1, 1, 8'h00, r);
    check(r == 8'hC3, "R6 data read", r, 8'hC3);
    check(n_adv == n0 + 1, "R6 one adv", n_adv, n0 + 1);

    // R8 4-bit mode
    set_mode(1);
    n0 = n_ins;
    xfer(0, 0, 8'h2F, r);
    check(n_ins == n0, "R8 no pulse after first nibble", n_ins, n0);
    xfer(0, 0, 8'h8F, r);
    check(n_ins == n0 + 1 && last_ins == 8'h28, "R8 nibble instr", last_ins, 8'h28);
    xfer(1, 0, 8'h90, r);
    xfer(1, 0, 8'hE0, r);
    check(last_dat == 8'h9E, "R8 nibble data", last_dat, 8'h9E);
    n0 = n_adv;
    xfer(1, 1, 8'h00, r);
    xfer(1, 1, 8'h00, r2);
    check(r == 8'hC0 && r2 == 8'h30, "R8 nibble read", {r, r2}, 16'hC030);
    check(n_adv == n0 + 1, "R8 one adv per byte", n_adv, n0 + 1);
    xfer(0, 1, 8'h00, r);
    xfer(0, 1, 8'h00, r2);
    check(r == 8'h20 && r2 == 8'hC0, "R8 nibble status", {r, r2}, 16'h20C0);

    // R9 phase reset on mode change
    xfer(0, 0, 8'h70, r);
    set_mode(0);
    set_mode(1);
    n0 = n_ins;
    xfer(0, 0, 8'h40, r);
    xfer(0, 0, 8'hD0, r);
    check(n_ins == n0 + 1 && last_ins == 8'h4D, "R9 restart upper nibble", last_ins, 8'h4D);
    xfer(0, 0, 8'h60, r);
    set_mode(0);
    n0 = n_ins;
    xfer(0, 0, 8'h11, r);
    check(n_ins == n0 + 1 && last_ins == 8'h11, "R9 8-bit after switch", last_ins, 8'h11);

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule